// File: doc/BRIEF.md
# Line Pipeline Control Generator

This block sequences a seven-stage line-streaming stereo pipeline from two inputs supplied by a top controller: a global enable and a one-cycle line reset. For every stage it drives a clock-gate style enable and a reset. All stages also share a pipeline-position number (Pn), which counts the eight clocks of one pipeline cycle, and a loop number (Ln), which counts the sixty pipeline cycles of one line operation. One line operation therefore lasts 480 clocks and produces one group of 60 depth points.

A line reset starts the first stage at once. Each later stage joins one pipeline cycle (8 clocks) after the stage before it. Operating settings are captured when a new line begins:
- the image width, counted in groups of 60 points;
- whether the next group follows automatically or waits for another line reset;
- how many prefetch lines must pass before the stages behind the input stage may run.

The block pulses a done flag once the last group of a line has finished. Dropping the global enable aborts all activity.

Top module: `line_pipe_ctrl`

## Requirements
- R1: After reset all stage enables, stage resets, Pn, Ln and done_o are zero.
- R2: While a line operation runs, pn_o advances by one every clock from 0 to 7 and wraps. ln_o advances by one whenever pn_o wraps and runs from 0 to 59, so one operation takes 480 clocks.
- R3: A line reset with global enable high, given while no operation runs, starts an operation. In the first clock after it, pn_o and ln_o are 0 and only stg_en_o bit 0 is high. Bit k (k = 0..6, stage k+1) comes on from clock 8k of the operation and stays on.
- R4: All seven bits of stg_rst_o are high for exactly the first clock of every line operation (new line, resumed group or automatically continued group) and low otherwise.
- R5: cfg_groups_i gives the line width in groups of 60 points. The value 0 is treated as 1, and values above 5 are treated as 5. When the last group's 480 clocks end, done_o is high for the single following clock and all stage enables are low.
- R6: When cfg_auto_i was set, the next group starts in the clock right after the previous one ends, and the enables stay high. Otherwise the enables drop and the counters rest at zero. The next line reset then resumes with the next group, and the stage enables build up again from stage 1.
- R7: Lines completed since the global enable last rose are counted. While that count is below cfg_prefetch_i, only stg_en_o bit 0 may be high.
- R8: A line reset that arrives while an operation runs is ignored: Pn, Ln and the enables carry on unchanged.
- R9: With glb_en_i low, the next clock leaves all enables low, Pn and Ln zero, group progress and the prefetch count cleared, and line resets are ignored.
- R10: The configuration inputs are captured only by a line reset that begins a new line. Changes made during an operation, or before a resume, have no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| glb_en_i | input | 1 | Global enable; low aborts and clears |
| line_rst_i | input | 1 | One-cycle line start / resume request |
| cfg_prefetch_i | input | 5 | Number of prefetch lines |
| cfg_groups_i | input | 3 | Line width in groups of 60 points |
| cfg_auto_i | input | 1 | Continue automatically to the next group |
| stg_en_o | output | 7 | Per-stage enable, bit 0 = input stage |
| stg_rst_o | output | 7 | Per-stage reset pulse |
| pn_o | output | 3 | Position within the pipeline cycle |
| ln_o | output | 6 | Loop number within the line operation |
| done_o | output | 1 | Line finished pulse |

## Verification
A single-group line is stepped through its stage-enable staircase and its Pn/Ln wrap points. A stray line reset injected mid-operation shows whether starts are blocked while an operation runs. Two-group lines, run once with automatic continuation and once without, separate gapless chaining from a paused resume. In the paused case, a configuration change made before the resume shows whether settings are captured at the wrong moment. Width values 0 and 7 exercise the clamping through the done timing. Prefetch runs of three lines check that gating releases exactly when the count is reached, and a mid-line global-enable drop checks the abort.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int NUM_STG = 7;
  localparam int PN_W    = 3;
  localparam int LN_W    = 6;
  localparam int LOOPS   = 60;
  localparam int GRP_W   = 3;
  localparam int MAX_GRP = 5;
  localparam int PF_W    = 5;
endpackage

// File: rtl/lpc_cycle_cnt.sv
module lpc_cycle_cnt #(
  parameter int PN_W  = 3,
  parameter int LN_W  = 6,
  parameter int LOOPS = 60
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            run_i,
  output logic [PN_W-1:0] pn_o,
  output logic [LN_W-1:0] ln_o,
  output logic            pc_end_o,
  output logic            op_end_o
);
  localparam logic [LN_W-1:0] LN_LAST = LN_W'(LOOPS - 1);

  logic [PN_W-1:0] pn_q;
  logic [LN_W-1:0] ln_q;

  assign pc_end_o = run_i & (&pn_q);
  assign op_end_o = pc_end_o & (ln_q == LN_LAST);
  assign pn_o     = pn_q;
  assign ln_o     = ln_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pn_q <= '0;
      ln_q <= '0;
    end else if (clr_i) begin
      pn_q <= '0;
      ln_q <= '0;
    end else if (run_i) begin
      pn_q <= pn_q + 1'b1;
      if (pc_end_o) ln_q <= op_end_o ? '0 : ln_q + 1'b1;
    end
  end

  a_r2_ln_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ln_q <= LN_LAST);
endmodule

// File: rtl/lpc_stage_chain.sv
module lpc_stage_chain #(
  parameter int NUM_STG = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               kill_i,
  input  logic               step_i,
  input  logic               gate_i,
  output logic [NUM_STG-1:0] en_o
);
  logic [NUM_STG-1:0] vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     vld_q <= '0;
    else if (kill_i) vld_q <= '0;
    else if (load_i) vld_q <= NUM_STG'(1);
    else if (step_i) vld_q <= vld_q | {vld_q[NUM_STG-2:0], 1'b0};
  end

  // input stage never gated by prefetch
  assign en_o[0] = vld_q[0];
  for (genvar k = 1; k < NUM_STG; k++) begin : g_gate
    assign en_o[k] = vld_q[k] & ~gate_i;
  end
endmodule

// File: rtl/lpc_line_seq.sv
module lpc_line_seq #(
  parameter int GRP_W   = 3,
  parameter int MAX_GRP = 5,
  parameter int PF_W    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic             line_rst_i,
  input  logic [PF_W-1:0]  cfg_prefetch_i,
  input  logic [GRP_W-1:0] cfg_groups_i,
  input  logic             cfg_auto_i,
  input  logic             op_end_i,
  output logic             active_o,
  output logic             start_o,
  output logic             kill_o,
  output logic             rst_pulse_o,
  output logic             done_o,
  output logic             gate_o
);
  logic             active_q, hold_q, auto_q, done_q, rst_q;
  logic [GRP_W-1:0] grp_q, grp_lim_q, grp_eff;
  logic [PF_W-1:0]  pf_lim_q, pf_cnt_q;
  logic             new_line, last, cont;

  assign start_o  = glb_en_i & line_rst_i & ~active_q;
  assign new_line = start_o & ~hold_q;
  assign last     = (grp_q == grp_lim_q - 1'b1);
  assign cont     = op_end_i & ~last & auto_q;
  assign kill_o   = ~glb_en_i | (op_end_i & ~cont);

  always_comb begin
    if (cfg_groups_i == '0)                      grp_eff = GRP_W'(1);
    else if (cfg_groups_i > GRP_W'(MAX_GRP))     grp_eff = GRP_W'(MAX_GRP);
    else                                         grp_eff = cfg_groups_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      hold_q    <= 1'b0;
      auto_q    <= 1'b0;
      done_q    <= 1'b0;
      rst_q     <= 1'b0;
      grp_q     <= '0;
      grp_lim_q <= GRP_W'(1);
      pf_lim_q  <= '0;
      pf_cnt_q  <= '0;
    end else if (!glb_en_i) begin
      active_q <= 1'b0;
      hold_q   <= 1'b0;
      done_q   <= 1'b0;
      rst_q    <= 1'b0;
      grp_q    <= '0;
      pf_cnt_q <= '0;
    end else begin
      done_q <= op_end_i & last;
      rst_q  <= start_o | cont;
      if (start_o) begin
        active_q <= 1'b1;
        hold_q   <= 1'b0;
        if (new_line) begin
          grp_q     <= '0;
          grp_lim_q <= grp_eff;
          auto_q    <= cfg_auto_i;
          pf_lim_q  <= cfg_prefetch_i;
        end else begin
          grp_q <= grp_q + 1'b1;
        end
      end else if (op_end_i) begin
        if (last) begin
          active_q <= 1'b0;
          grp_q    <= '0;
          if (pf_cnt_q != '1) pf_cnt_q <= pf_cnt_q + 1'b1;
        end else if (auto_q) begin
          grp_q <= grp_q + 1'b1;
        end else begin
          active_q <= 1'b0;
          hold_q   <= 1'b1;
        end
      end
    end
  end

  assign active_o    = active_q;
  assign rst_pulse_o = rst_q;
  assign done_o      = done_q;
  assign gate_o      = pf_cnt_q < pf_lim_q;
endmodule

// File: rtl/line_pipe_ctrl.sv
module line_pipe_ctrl
  import lpc_pkg::*;
#(
  parameter int N_STG  = NUM_STG,
  parameter int P_W    = PN_W,
  parameter int L_W    = LN_W,
  parameter int N_LOOP = LOOPS,
  parameter int G_W    = GRP_W,
  parameter int G_MAX  = MAX_GRP,
  parameter int F_W    = PF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             glb_en_i,
  input  logic             line_rst_i,
  input  logic [F_W-1:0]   cfg_prefetch_i,
  input  logic [G_W-1:0]   cfg_groups_i,
  input  logic             cfg_auto_i,
  output logic [N_STG-1:0] stg_en_o,
  output logic [N_STG-1:0] stg_rst_o,
  output logic [P_W-1:0]   pn_o,
  output logic [L_W-1:0]   ln_o,
  output logic             done_o
);
  localparam logic [L_W-1:0] LN_LAST = L_W'(N_LOOP - 1);

  logic active, start, kill, rst_pulse, gate, pc_end, op_end;

  lpc_line_seq #(.GRP_W(G_W), .MAX_GRP(G_MAX), .PF_W(F_W)) u_seq (
    .clk_i, .rst_ni, .glb_en_i, .line_rst_i, .cfg_prefetch_i, .cfg_groups_i,
    .cfg_auto_i, .op_end_i(op_end), .active_o(active), .start_o(start),
    .kill_o(kill), .rst_pulse_o(rst_pulse), .done_o, .gate_o(gate)
  );

  lpc_cycle_cnt #(.PN_W(P_W), .LN_W(L_W), .LOOPS(N_LOOP)) u_cnt (
    .clk_i, .rst_ni, .clr_i(start | ~glb_en_i), .run_i(active),
    .pn_o, .ln_o, .pc_end_o(pc_end), .op_end_o(op_end)
  );

  lpc_stage_chain #(.NUM_STG(N_STG)) u_chain (
    .clk_i, .rst_ni, .load_i(start), .kill_i(kill), .step_i(pc_end),
    .gate_i(gate), .en_o(stg_en_o)
  );

  assign stg_rst_o = {N_STG{rst_pulse}};

  a_r2_pn_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stg_en_o[0] && $past(stg_en_o[0])) |-> pn_o == P_W'($past(pn_o) + 1'b1));
  a_r3_stage_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|stg_en_o[N_STG-1:1]) |-> stg_en_o[0]);
  a_r4_rst_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stg_en_o[0]) |-> (&stg_rst_o));
  a_r5_done_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ln_o == LN_LAST && (&pn_o)));
  a_r9_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(glb_en_i) |-> stg_en_o == '0);
endmodule

// File: tb/line_pipe_ctrl_bench.sv
module line_pipe_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       glb_en_i = 1'b0;
  logic       line_rst_i = 1'b0;
  logic [4:0] cfg_prefetch_i = '0;
  logic [2:0] cfg_groups_i = 3'd1;
  logic       cfg_auto_i = 1'b0;
  logic [6:0] stg_en_o, stg_rst_o;
  logic [2:0] pn_o;
  logic [5:0] ln_o;
  logic       done_o;

  int n_run = 0, n_fail = 0, cyc = 0, c0 = 0, tnow = 0;
  bit reported = 0;
  int exp_q[$];

  line_pipe_ctrl u_line_pipe_ctrl (.*);

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (t=%0d)", req, act, exp, tnow);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // monitor: pop expected done cycles
  always @(negedge clk_i) begin
    if (rst_ni && done_o) begin
      if (exp_q.size() == 0) check("R5 unexpected done", 1, 0);
      else check("R5 done cycle", cyc, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=finish");
    report();
  end

  task automatic go(input int t);
    while (tnow < t) begin
      @(negedge clk_i);
      tnow++;
    end
  endtask

  task automatic start_line(input int done_after);
    line_rst_i = 1'b1;
    @(negedge clk_i);
    line_rst_i = 1'b0;
    tnow = 0;
    c0 = cyc;
    if (done_after > 0) exp_q.push_back(c0 + done_after);
  endtask

  task automatic glb_cycle();
    glb_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    glb_en_i = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R1 en", stg_en_o, 0);
    check("R1 rst", stg_rst_o, 0);
    check("R1 pn", pn_o, 0);
    check("R1 ln", ln_o, 0);
    check("R1 done", done_o, 0);

    // R9: line reset ignored with global enable low
    start_line(0);
    go(3);
    check("R9 ignored start", stg_en_o, 0);
    glb_en_i = 1'b1;
    @(negedge clk_i);

    // single group, manual
    cfg_groups_i = 3'd1; cfg_auto_i = 1'b0; cfg_prefetch_i = 5'd0;
    start_line(480);
    check("R3 first en", stg_en_o, 7'h01);
    check("R4 rst on", stg_rst_o, 7'h7f);
    check("R3 pn0", pn_o, 0);
    check("R3 ln0", ln_o, 0);
    go(1);
    check("R4 rst off", stg_rst_o, 0);
    check("R2 pn step", pn_o, 1);
    go(7);
    check("R2 pn7", pn_o, 7);
    check("R3 en t7", stg_en_o, 7'h01);
    go(8);
    check("R3 en t8", stg_en_o, 7'h03);
    check("R2 ln1", ln_o, 1);
    check("R2 pn wrap", pn_o, 0);
    go(47);
    check("R3 en t47", stg_en_o, 7'h3f);
    go(48);
    check("R3 en t48", stg_en_o, 7'h7f);
    go(99);
    start_line(0);
    tnow = 100;
    check("R8 pn", pn_o, 4);
    check("R8 ln", ln_o, 12);
    check("R8 en", stg_en_o, 7'h7f);
    check("R8 rst", stg_rst_o, 0);
    go(479);
    check("R2 pn end", pn_o, 7);
    check("R2 ln end", ln_o, 59);
    go(480);
    check("R5 en off", stg_en_o, 0);
    go(482);
    check("R5 pn rest", pn_o, 0);

    // two groups, automatic
    cfg_groups_i = 3'd2; cfg_auto_i = 1'b1;
    start_line(960);
    go(479);
    check("R6 en before", stg_en_o, 7'h7f);
    go(480);
    check("R4 rst cont", stg_rst_o, 7'h7f);
    check("R6 en cont", stg_en_o, 7'h7f);
    check("R6 ln cont", ln_o, 0);
    go(481);
    check("R4 rst cont off", stg_rst_o, 0);
    go(960);
    check("R5 en off 2", stg_en_o, 0);
    go(962);

    // two groups, paused
    cfg_auto_i = 1'b0;
    start_line(0);
    go(480);
    check("R6 paused en", stg_en_o, 0);
    check("R6 paused rst", stg_rst_o, 0);
    go(500);
    check("R6 paused en2", stg_en_o, 0);
    check("R6 paused pn", pn_o, 0);
    cfg_groups_i = 3'd1; // R10: must not be captured by a resume
    start_line(480);
    check("R6 resume en", stg_en_o, 7'h01);
    check("R4 resume rst", stg_rst_o, 7'h7f);
    go(8);
    check("R6 resume chain", stg_en_o, 7'h03);
    go(482);

    // width clamps
    cfg_groups_i = 3'd0;
    start_line(480);
    go(482);
    cfg_groups_i = 3'd7; cfg_auto_i = 1'b1;
    start_line(2400);
    go(1920);
    check("R5 clamp fifth group", stg_rst_o, 7'h7f);
    go(2402);

    // prefetch with config change mid-line
    cfg_auto_i = 1'b0; cfg_groups_i = 3'd1; cfg_prefetch_i = 5'd2;
    glb_cycle();
    start_line(480);
    go(60);
    check("R7 gated L1", stg_en_o, 7'h01);
    go(200);
    cfg_prefetch_i = 5'd0;
    go(201);
    check("R10 no midline effect", stg_en_o, 7'h01);
    go(482);
    start_line(480);
    go(60);
    check("R10 captured at new line", stg_en_o, 7'h7f);
    go(482);

    // prefetch count release
    cfg_prefetch_i = 5'd2;
    glb_cycle();
    start_line(480);
    go(60);
    check("R7 gated La", stg_en_o, 7'h01);
    go(482);
    start_line(480);
    go(60);
    check("R7 gated Lb", stg_en_o, 7'h01);
    go(482);
    start_line(480);
    go(60);
    check("R7 released Lc", stg_en_o, 7'h7f);
    go(482);

    // abort
    cfg_prefetch_i = 5'd0;
    start_line(0);
    go(100);
    glb_en_i = 1'b0;
    go(101);
    check("R9 abort en", stg_en_o, 0);
    check("R9 abort pn", pn_o, 0);
    check("R9 abort ln", ln_o, 0);
    glb_en_i = 1'b1;
    go(103);
    check("R9 stays idle", stg_en_o, 0);
    start_line(480);
    go(60);
    check("R9 fresh line", stg_en_o, 7'h7f);
    go(485);

    check("R5 all done seen", exp_q.size(), 0);
    report();
  end
endmodule